// File: doc/BRIEF.md
# Power-down entry and wake-up sequencer

This block controls how a chip goes into its power-down state and how it comes back out. Software first sets an arm bit through a small write port that is guarded by an unlock input. The block then waits for the CPU to report that it is asleep. Only when both conditions hold does the sequencer stop the high-speed oscillator, send the PLL a power-down request and drop the system-clock-ready signal. Any wake-up source then brings the chip back.

On wake-up the arm bit clears itself, so every later power-down needs a fresh arm. A sticky wake flag is set. If the delay-enable bit is set, the clock stays held for a fixed stabilisation window counted on the free-running clock. Otherwise it is released at once. The wake flag is cleared by writing one to it, and it drives an interrupt that is qualified by an enable bit.

Top module: `pdn_seq_top`

## Requirements
- R1: Power-down (PLL request high, clock-ready low) is entered only after the arm bit (write-data bit 0) has been set and `cpu_sleep` is then seen high. The sequence is: arm set on one edge, armed state on the next edge, power-down on the first later edge with `cpu_sleep` high. `cpu_sleep` with the arm bit clear has no effect.
- R2: The wake edge that leaves power-down clears the arm bit (`ctrl_rd[0]`). With `cpu_sleep` still high afterwards, power-down is not re-entered.
- R3: With the delay-enable bit (bit 1) set, `sysclk_ready` stays low for exactly DLY_CYC (512) cycles after the wake edge. The count starts from zero on every wake.
- R4: With the delay-enable bit clear, `sysclk_ready` is high right after the wake edge.
- R5: A wake source that pulses while the block is not in power-down sets no flag and starts no sequence.
- R6: A wake event in power-down sets `wake_flag`. Writing 1 to bit 4 clears it, whatever the unlock input is. Writing 0 there leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R7: `wake_irq` is high exactly when `wake_flag` and the interrupt-enable bit (bit 2) are both 1.
- R8: During power-down `osc_en` is low, `pll_pd_req` is high and `sysclk_ready` is low. Outside power-down, `pll_pd_req` is low and `osc_en` follows the oscillator bit (bit 3).
- R9: The arm, delay-enable, interrupt-enable and oscillator bits change only on a write made with `cfg_unlock` high. `ctrl_rd` reads them back as {osc, ien, dly, arm}.
- R10: After reset all control bits and the flag are 0, `osc_en`, `pll_pd_req` and `wake_irq` are 0, and `sysclk_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the control byte |
| cfg_unlock | input | 1 | Allows protected bits to change on this write |
| cfg_wdata | input | 5 | Write data: 0 arm, 1 delay-enable, 2 irq-enable, 3 oscillator, 4 flag clear |
| cpu_sleep | input | 1 | CPU reports sleep |
| wake_src | input | WAKE_W | Wake-up source events |
| osc_en | output | 1 | High-speed oscillator enable |
| pll_pd_req | output | 1 | PLL power-down request |
| sysclk_ready | output | 1 | System clock released |
| wake_flag | output | 1 | Sticky wake-up flag |
| wake_irq | output | 1 | Qualified wake interrupt |
| ctrl_rd | output | 4 | Control bits {osc, ien, dly, arm} |

## Verification
Two events can land on the same edge. A wake source can fire during power-down while software writes a one to clear the flag. The bench provokes this by driving both on the same negative edge while the block sits in power-down. It expects the flag and the interrupt to be high afterwards, because the set wins. A second collision is a wake event while the block is only armed, with no sleep yet. There the bench expects no flag and no entry. Randomised writes with random unlock and wake pulses are then compared cycle by cycle against a bench model of the control bits and the flag.

// File: rtl/pdn_pkg.sv
package pdn_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ARMED = 2'd1,
    ST_PDOWN = 2'd2,
    ST_WDLY  = 2'd3
  } pdn_state_t;

  // field positions inside the write data byte
  localparam int FB_ARM  = 0;
  localparam int FB_DLY  = 1;
  localparam int FB_IEN  = 2;
  localparam int FB_OSC  = 3;
  localparam int FB_FCLR = 4;
  localparam int WDATA_W = FB_FCLR + 1;
  localparam int CTRL_W  = 4;

  typedef struct packed {
    logic osc;
    logic ien;
    logic dly;
    logic arm;
  } pdn_ctrl_t;
endpackage

// File: rtl/pdn_ctrl_regs.sv
module pdn_ctrl_regs
  import pdn_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic               unlock,
  input  logic [WDATA_W-1:0] wdata,
  input  logic               wake_evt,
  output pdn_ctrl_t          ctrl_q,
  output pdn_ctrl_t          ctrl_d,
  output logic               flag_q,
  output logic               flag_d
);
  always_comb begin
    ctrl_d = ctrl_q;
    if (we && unlock) begin
      ctrl_d.arm = wdata[FB_ARM];
      ctrl_d.dly = wdata[FB_DLY];
      ctrl_d.ien = wdata[FB_IEN];
      ctrl_d.osc = wdata[FB_OSC];
    end
    // wake always disarms, over any same-cycle write
    if (wake_evt) ctrl_d.arm = 1'b0;
  end

  always_comb begin
    flag_d = flag_q;
    if (we && wdata[FB_FCLR]) flag_d = 1'b0;
    // a new wake outranks a clear in the same cycle
    if (wake_evt) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/pdn_fsm.sv
module pdn_fsm
  import pdn_pkg::*;
#(
  parameter int DLY_CYC = 512
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       arm,
  input  logic       dly_en,
  input  logic       cpu_sleep,
  input  logic       wake_any,
  output pdn_state_t state_d,
  output logic       wake_evt
);
  localparam int CW = (DLY_CYC > 2) ? $clog2(DLY_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DLY_CYC - 1);

  pdn_state_t    state_q;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    wake_evt = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (arm) state_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (!arm)          state_d = ST_RUN;
        else if (cpu_sleep) state_d = ST_PDOWN;
      end
      ST_PDOWN: begin
        // counter is frozen here; it restarts at zero on the wake edge
        if (wake_any) begin
          wake_evt = 1'b1;
          cnt_d    = '0;
          state_d  = dly_en ? ST_WDLY : ST_RUN;
        end
      end
      ST_WDLY: begin
        if (cnt_q == CNT_LAST) state_d = ST_RUN;
        else                   cnt_d   = cnt_q + 1'b1;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/pdn_out_stage.sv
module pdn_out_stage
  import pdn_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pdn_state_t state_d,
  input  pdn_ctrl_t  ctrl_d,
  input  logic       flag_d,
  output logic       osc_en,
  output logic       pll_pd_req,
  output logic       sysclk_ready,
  output logic       wake_irq
);
  logic in_pd, held;

  always_comb begin
    in_pd = (state_d == ST_PDOWN);
    held  = in_pd || (state_d == ST_WDLY);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      osc_en       <= 1'b0;
      pll_pd_req   <= 1'b0;
      sysclk_ready <= 1'b1;
      wake_irq     <= 1'b0;
    end else begin
      osc_en       <= ctrl_d.osc && !in_pd;
      pll_pd_req   <= in_pd;
      sysclk_ready <= !held;
      wake_irq     <= flag_d && ctrl_d.ien;
    end
  end
endmodule

// File: rtl/pdn_seq_top.sv
module pdn_seq_top
  import pdn_pkg::*;
#(
  parameter int DLY_CYC = 512,
  parameter int WAKE_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic                 cfg_unlock,
  input  logic [WDATA_W-1:0]   cfg_wdata,
  input  logic                 cpu_sleep,
  input  logic [WAKE_W-1:0]    wake_src,
  output logic                 osc_en,
  output logic                 pll_pd_req,
  output logic                 sysclk_ready,
  output logic                 wake_flag,
  output logic                 wake_irq,
  output logic [CTRL_W-1:0]    ctrl_rd
);
  pdn_ctrl_t  ctrl_q, ctrl_d;
  logic       flag_q, flag_d;
  pdn_state_t state_d;
  logic       wake_evt;
  logic       wake_any;

  assign wake_any = |wake_src;

  pdn_ctrl_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .unlock   (cfg_unlock),
    .wdata    (cfg_wdata),
    .wake_evt (wake_evt),
    .ctrl_q   (ctrl_q),
    .ctrl_d   (ctrl_d),
    .flag_q   (flag_q),
    .flag_d   (flag_d)
  );

  pdn_fsm #(.DLY_CYC(DLY_CYC)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .arm       (ctrl_q.arm),
    .dly_en    (ctrl_q.dly),
    .cpu_sleep (cpu_sleep),
    .wake_any  (wake_any),
    .state_d   (state_d),
    .wake_evt  (wake_evt)
  );

  pdn_out_stage u_out (
    .clk          (clk),
    .rst          (rst),
    .state_d      (state_d),
    .ctrl_d       (ctrl_d),
    .flag_d       (flag_d),
    .osc_en       (osc_en),
    .pll_pd_req   (pll_pd_req),
    .sysclk_ready (sysclk_ready),
    .wake_irq     (wake_irq)
  );

  assign wake_flag = flag_q;
  assign ctrl_rd   = ctrl_q;
endmodule

// File: rtl/pdn_chk.sv
module pdn_chk #(
  parameter int DLY_CYC = 512
) (
  input logic       clk,
  input logic       rst,
  input logic       cfg_we,
  input logic       cfg_unlock,
  input logic       cpu_sleep,
  input logic       osc_en,
  input logic       pll_pd_req,
  input logic       sysclk_ready,
  input logic       wake_flag,
  input logic       wake_irq,
  input logic [3:0] ctrl_rd
);
  localparam int HW = $clog2(DLY_CYC) + 2;
  logic [HW-1:0] hold_cnt;

  // cycles with the clock held while not in power-down
  always_ff @(posedge clk) begin
    if (rst) hold_cnt <= '0;
    else if (!sysclk_ready && !pll_pd_req) hold_cnt <= hold_cnt + 1'b1;
    else hold_cnt <= '0;
  end

  assert_entry_needs_arm_R1: assert property (@(posedge clk) disable iff (rst)
    (pll_pd_req && !$past(pll_pd_req)) |-> ($past(cpu_sleep) && $past(ctrl_rd[0])));

  assert_wake_disarms_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_pd_req) |-> !ctrl_rd[0]);

  assert_release_window_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(sysclk_ready) |-> (hold_cnt == HW'(0) || hold_cnt == HW'(DLY_CYC)));

  assert_wake_sets_flag_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_pd_req) |-> wake_flag);

  assert_irq_qualified_R7: assert property (@(posedge clk) disable iff (rst)
    wake_irq == (wake_flag && ctrl_rd[2]));

  assert_pd_outputs_R8: assert property (@(posedge clk) disable iff (rst)
    pll_pd_req |-> (!osc_en && !sysclk_ready));

  assert_locked_write_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_unlock) |=> $stable(ctrl_rd[3:1]));
endmodule

bind pdn_seq_top pdn_chk #(.DLY_CYC(DLY_CYC)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_we       (cfg_we),
  .cfg_unlock   (cfg_unlock),
  .cpu_sleep    (cpu_sleep),
  .osc_en       (osc_en),
  .pll_pd_req   (pll_pd_req),
  .sysclk_ready (sysclk_ready),
  .wake_flag    (wake_flag),
  .wake_irq     (wake_irq),
  .ctrl_rd      (ctrl_rd)
);

// File: tb/tb_pdn_seq_top.sv
`timescale 1ns/1ps
module tb_pdn_seq_top;
  localparam int DLY = 512;
  localparam int WW  = 4;

  logic clk = 1'b0;
  logic rst;
  logic cfg_we, cfg_unlock, cpu_sleep;
  logic [4:0] cfg_wdata;
  logic [WW-1:0] wake_src;
  logic osc_en, pll_pd_req, sysclk_ready, wake_flag, wake_irq;
  logic [3:0] ctrl_rd;

  int nvec = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  pdn_seq_top #(.DLY_CYC(DLY), .WAKE_W(WW)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_unlock(cfg_unlock),
    .cfg_wdata(cfg_wdata), .cpu_sleep(cpu_sleep), .wake_src(wake_src),
    .osc_en(osc_en), .pll_pd_req(pll_pd_req), .sysclk_ready(sysclk_ready),
    .wake_flag(wake_flag), .wake_irq(wake_irq), .ctrl_rd(ctrl_rd)
  );

  function automatic logic exp_irq(input logic flag, input logic ien);
    return flag & ien;
  endfunction

  function automatic logic [3:0] exp_ctrl(input logic [3:0] cur, input logic we,
                                          input logic unl, input logic [4:0] wd);
    return (we && unl) ? wd[3:0] : cur;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] d, input logic unl);
    cfg_we = 1'b1; cfg_wdata = d; cfg_unlock = unl;
    @(negedge clk);
    cfg_we = 1'b0; cfg_unlock = 1'b0; cfg_wdata = '0;
  endtask

  // arm must already be set; enters power-down, then wakes with delay
  task automatic delayed_wake(input string tag);
    cpu_sleep = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk({tag, " pd entered"}, pll_pd_req, 1);
    repeat (7) @(negedge clk);
    wake_src = 4'b0010;
    @(negedge clk);
    wake_src = '0;
    chk({tag, " held after wake"}, sysclk_ready, 0);
    repeat (DLY - 1) @(negedge clk);
    chk({tag, " held at last cycle"}, sysclk_ready, 0);
    @(negedge clk);
    chk({tag, " released after window"}, sysclk_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [3:0] m_ctrl;
    logic       m_flag;
    int unsigned sd;
    rst = 1'b1; cfg_we = 0; cfg_unlock = 0; cfg_wdata = '0;
    cpu_sleep = 0; wake_src = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 ctrl", ctrl_rd, 0);
    chk("R10 ready", sysclk_ready, 1);
    chk("R10 pll", pll_pd_req, 0);
    chk("R10 osc", osc_en, 0);
    chk("R10 flag/irq", {wake_flag, wake_irq}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R1 sleep with no arm does nothing
    cpu_sleep = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 unarmed sleep pll", pll_pd_req, 0);
    chk("R1 unarmed sleep ready", sysclk_ready, 1);
    cpu_sleep = 1'b0;

    // R9 locked write ignored
    wr(5'b01111, 1'b0);
    chk("R9 locked write", ctrl_rd, 4'h0);
    wr(5'b01111, 1'b1);
    chk("R9 unlocked write", ctrl_rd, 4'hF);
    chk("R8 osc follows bit", osc_en, 1);

    // R5 wake while armed only
    wake_src = 4'b1000;
    @(negedge clk);
    wake_src = '0;
    @(negedge clk);
    chk("R5 armed wake flag", wake_flag, 0);
    chk("R5 armed wake no pd", pll_pd_req, 0);
    chk("R5 arm kept", ctrl_rd[0], 1);

    // R1 entry on sleep while armed
    cpu_sleep = 1'b1;
    @(negedge clk);
    chk("R1 pd entry", pll_pd_req, 1);
    chk("R8 osc low in pd", osc_en, 0);
    chk("R8 ready low in pd", sysclk_ready, 0);
    repeat (6) @(negedge clk);
    chk("R8 pd held", pll_pd_req, 1);

    // wake with delay; sleep stays high
    wake_src = 4'b0100;
    @(negedge clk);
    wake_src = '0;
    chk("R6 flag set", wake_flag, 1);
    chk("R7 irq on", wake_irq, exp_irq(1'b1, 1'b1));
    chk("R2 arm cleared", ctrl_rd[0], 0);
    chk("R8 pll released", pll_pd_req, 0);
    chk("R8 osc back", osc_en, 1);
    chk("R3 held at wake", sysclk_ready, 0);
    repeat (DLY - 1) @(negedge clk);
    chk("R3 held 511", sysclk_ready, 0);
    @(negedge clk);
    chk("R3 released 512", sysclk_ready, 1);
    repeat (5) @(negedge clk);
    chk("R2 no re-entry", pll_pd_req, 0);

    // R6 write-one-to-clear
    wr(5'b00000, 1'b0);
    chk("R6 write zero keeps", wake_flag, 1);
    wr(5'b10000, 1'b0);
    chk("R6 write one clears", wake_flag, 0);
    chk("R7 irq off", wake_irq, 0);

    // R4 no delay, plus simultaneous set/clear
    wr(5'b01101, 1'b1);
    @(negedge clk);
    @(negedge clk);
    chk("R1 second entry", pll_pd_req, 1);
    wake_src = 4'b0001;
    cfg_we = 1'b1; cfg_wdata = 5'b10000;
    @(negedge clk);
    wake_src = '0; cfg_we = 1'b0; cfg_wdata = '0;
    chk("R6 set beats clear", wake_flag, 1);
    chk("R4 immediate release", sysclk_ready, 1);
    chk("R7 irq with set", wake_irq, 1);

    // R7 enable qualifies
    wr(5'b00000, 1'b1);
    chk("R7 ien off", wake_irq, 0);
    chk("R7 flag kept", wake_flag, 1);
    wr(5'b00100, 1'b1);
    chk("R7 ien on", wake_irq, 1);
    wr(5'b10100, 1'b0);
    chk("R7 cleared", wake_irq, 0);

    // R3 counter restarts on a later wake
    wr(5'b01011, 1'b1);
    delayed_wake("R3 second");
    cpu_sleep = 1'b0;

    // random phase: no sleep, model of bits and flag
    wr(5'b10000, 1'b1);
    m_ctrl = 4'h0; m_flag = 1'b0;
    sd = $urandom(32'd20240611);
    for (int i = 0; i < 400; i++) begin
      logic we, un;
      logic [4:0] wd;
      we = 1'($urandom % 2);
      un = 1'($urandom % 2);
      wd = 5'($urandom);
      cfg_we = we; cfg_unlock = un; cfg_wdata = wd;
      wake_src = WW'($urandom % 3 == 0 ? $urandom : 0);
      @(negedge clk);
      cfg_we = 0; cfg_unlock = 0; cfg_wdata = '0; wake_src = '0;
      m_ctrl = exp_ctrl(m_ctrl, we, un, wd);
      if (we && wd[4]) m_flag = 1'b0;
      chk("R9 random ctrl", ctrl_rd, m_ctrl);
      chk("R5 random flag", wake_flag, m_flag);
      chk("R7 random irq", wake_irq, exp_irq(m_flag, m_ctrl[2]));
      chk("R8 random osc", {osc_en, pll_pd_req, sysclk_ready}, {m_ctrl[3], 1'b0, 1'b1});
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule